// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Buffer

This block keeps a small set of recent address translations. Each slot holds a virtual page number, the process ID that owns it, a physical page number, three access-right bits and a dirty bit. A lookup presents a virtual address, a process ID and an access kind. One clock later it gets back exactly one of four outcomes: clean hit, miss, protection fault, or dirty-update request. The physical address is returned with it.

Because every slot carries its owner's process ID, translations for several address spaces can sit in the buffer at the same time. A context switch then needs no flush. A flush of everything, or of the slots owned by one process ID, is still available.

A page-table walker outside the block handles a miss and writes the complete translation through the fill port. The walker also sets the dirty bit in answer to a dirty-update request.

Top module: `ptag_tlb`

## Requirements
- R1: Placement is fully associative. Any slot may hold any (page, process ID) pair, and all ENTRIES slots can hold valid translations at once.
- R2: A lookup accepted at a clock edge (lk_valid high) produces rsp_valid high after that edge, and the result is held until the next edge. With no request, rsp_valid is low. Lookups may be issued in consecutive cycles.
- R3: A lookup matches a slot only when the slot is valid and both its page number and its process ID equal the request. Without a match the outcome is a miss.
- R4: On a match, rsp_pa is the slot's physical page number concatenated above the request's low OFS_W offset bits, which are copied unchanged. On a miss, rsp_pa is zero.
- R5: Access kinds are encoded as 0 = read, 1 = write, 2 = execute and 3 = reserved. Rights bit 0 grants read, bit 1 grants write and bit 2 grants execute. A match whose rights lack the requested kind reports a fault, and kind 3 always faults.
- R6: A permitted write that matches a slot whose dirty bit is clear reports a dirty-update request and no hit.
- R7: Each response raises exactly one of rsp_hit, rsp_miss, rsp_fault and rsp_dirty. No outcome flag is raised without a response.
- R8: inv_all clears every slot, so every following lookup misses.
- R9: inv_pid_en clears only the slots whose process ID equals inv_pid. Translations owned by other process IDs are kept.
- R10: A fill for a (page, process ID) pair that is already present overwrites that slot in place, so the pair is never held twice.
- R11: A fill for a new pair takes the lowest-numbered invalid slot. If every slot is valid, it takes the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, only on such a replacement.
- R12: When a fill arrives in the same cycle as an invalidation, the invalidation is applied first, so the filled translation remains valid.
- R13: After reset, all slots are invalid and no response or outcome flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VPN_W+OFS_W | Virtual address to translate |
| lk_pid | input | PID_W | Process ID of the lookup |
| lk_kind | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 reserved) |
| fl_valid | input | 1 | Fill strobe |
| fl_vpn | input | VPN_W | Fill virtual page number |
| fl_pid | input | PID_W | Fill process ID |
| fl_ppn | input | PPN_W | Fill physical page number |
| fl_rights | input | 3 | Fill rights {execute, write, read} |
| fl_dirty | input | 1 | Fill dirty bit |
| inv_all | input | 1 | Invalidate every slot |
| inv_pid_en | input | 1 | Invalidate the slots of one process ID |
| inv_pid | input | PID_W | Process ID to invalidate |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Clean hit |
| rsp_miss | output | 1 | No matching slot |
| rsp_fault | output | 1 | Rights violation |
| rsp_dirty | output | 1 | Write to a clean page; dirty bit must be set |
| rsp_pa | output | PPN_W+OFS_W | Physical address |

## Verification
The bench builds the block with ENTRIES = 4 and PID_W = 4, keeping the default page and offset widths. With only four slots, a short run fills the buffer completely. That brings round-robin eviction and its wrap within reach, along with the rule that an invalid hole is reused before the pointer is. The small process ID width still leaves three owners to share the buffer. This lets the bench clear one owner selectively while the others' translations survive.

// File: rtl/ptag_tlb.sv
module ptag_tlb #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int PID_W   = 8,
  parameter int PPN_W   = 21,
  parameter int OFS_W   = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic [VPN_W+OFS_W-1:0]   lk_va,
  input  logic [PID_W-1:0]         lk_pid,
  input  logic [1:0]               lk_kind,
  input  logic                     fl_valid,
  input  logic [VPN_W-1:0]         fl_vpn,
  input  logic [PID_W-1:0]         fl_pid,
  input  logic [PPN_W-1:0]         fl_ppn,
  input  logic [2:0]               fl_rights,
  input  logic                     fl_dirty,
  input  logic                     inv_all,
  input  logic                     inv_pid_en,
  input  logic [PID_W-1:0]         inv_pid,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_miss,
  output logic                     rsp_fault,
  output logic                     rsp_dirty,
  output logic [PPN_W+OFS_W-1:0]   rsp_pa
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int PA_W  = PPN_W + OFS_W;

  logic [ENTRIES-1:0] vld_q, vld_d, dty_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PID_W-1:0]   pid_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [2:0]         rgt_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;

  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] lk_hitv, fl_hitv;

  assign lk_vpn = lk_va[VPN_W+OFS_W-1:OFS_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_hitv[g] = vld_q[g] && vpn_q[g] == lk_vpn && pid_q[g] == lk_pid;
    assign fl_hitv[g] = vld_q[g] && vpn_q[g] == fl_vpn && pid_q[g] == fl_pid;
  end

  logic [PPN_W-1:0] lk_ppn;
  logic [2:0]       lk_rgt;
  logic             lk_dty;

  always_comb begin
    lk_ppn = '0;
    lk_rgt = '0;
    lk_dty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hitv[i]) begin
        lk_ppn = lk_ppn | ppn_q[i];
        lk_rgt = lk_rgt | rgt_q[i];
        lk_dty = lk_dty | dty_q[i];
      end
    end
  end

  logic lk_any, perm;
  logic o_hit, o_miss, o_fault, o_dirty;

  assign lk_any = |lk_hitv;

  always_comb begin
    case (lk_kind)
      2'd0:    perm = lk_rgt[0];
      2'd1:    perm = lk_rgt[1];
      2'd2:    perm = lk_rgt[2];
      default: perm = 1'b0;
    endcase
  end

  assign o_miss  = lk_valid && !lk_any;
  assign o_fault = lk_valid && lk_any && !perm;
  assign o_dirty = lk_valid && lk_any && perm && lk_kind == 2'd1 && !lk_dty;
  assign o_hit   = lk_valid && lk_any && perm && !o_dirty;

  logic [IDX_W-1:0] free_idx, same_idx, victim;
  logic             use_rr;

  always_comb begin
    free_idx = '0;
    same_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IDX_W'(i);
      if (fl_hitv[i]) same_idx = IDX_W'(i);
    end
  end

  assign use_rr = !(|fl_hitv) && (&vld_q);
  assign victim = (|fl_hitv) ? same_idx : (use_rr ? rr_q : free_idx);

  always_comb begin
    vld_d = vld_q;
    if (inv_all) vld_d = '0;
    if (inv_pid_en) begin
      for (int i = 0; i < ENTRIES; i++)
        if (pid_q[i] == inv_pid) vld_d[i] = 1'b0;
    end
    if (fl_valid) vld_d[victim] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (fl_valid && use_rr)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fl_valid) begin
      vpn_q[victim] <= fl_vpn;
      pid_q[victim] <= fl_pid;
      ppn_q[victim] <= fl_ppn;
      rgt_q[victim] <= fl_rights;
      dty_q[victim] <= fl_dirty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= o_hit;
      rsp_miss  <= o_miss;
      rsp_fault <= o_fault;
      rsp_dirty <= o_dirty;
      rsp_pa    <= (lk_valid && lk_any) ? {lk_ppn, lk_va[OFS_W-1:0]} : PA_W'(0);
    end
  end

endmodule

// File: rtl/ptag_tlb_chk.sv
module ptag_tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 34,
  parameter int OFS_W   = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [VA_W-1:0]    lk_va,
  input logic [1:0]         lk_kind,
  input logic               fl_valid,
  input logic               inv_all,
  input logic [ENTRIES-1:0] vld,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_fault,
  input logic               rsp_dirty,
  input logic [PA_W-1:0]    rsp_pa
);

  p_req_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault, rsp_dirty}) == 1);

  p_no_stray_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault || rsp_dirty));

  p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rsp_miss || rsp_pa[OFS_W-1:0] == $past(lk_va[OFS_W-1:0])));

  p_miss_zero_pa_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> rsp_pa == '0);

  p_dirty_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_kind != 2'd1 |=> !rsp_dirty);

  p_reserved_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_kind == 2'd3 |=> !rsp_hit);

  p_flush_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && !fl_valid |=> vld == '0);

  p_fill_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fl_valid |=> vld != '0);

endmodule

bind ptag_tlb ptag_tlb_chk #(
  .ENTRIES(ENTRIES),
  .VA_W   (VPN_W + OFS_W),
  .PA_W   (PPN_W + OFS_W),
  .OFS_W  (OFS_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_valid (lk_valid),
  .lk_va    (lk_va),
  .lk_kind  (lk_kind),
  .fl_valid (fl_valid),
  .inv_all  (inv_all),
  .vld      (vld_q),
  .rsp_valid(rsp_valid),
  .rsp_hit  (rsp_hit),
  .rsp_miss (rsp_miss),
  .rsp_fault(rsp_fault),
  .rsp_dirty(rsp_dirty),
  .rsp_pa   (rsp_pa)
);

// File: tb/test_ptag_tlb.sv
module test_ptag_tlb;

  localparam int ENTRIES = 4;
  localparam int VPN_W   = 19;
  localparam int PID_W   = 4;
  localparam int PPN_W   = 21;
  localparam int OFS_W   = 13;
  localparam int VA_W    = VPN_W + OFS_W;
  localparam int PA_W    = PPN_W + OFS_W;

  localparam int MISS = 0, HIT = 1, FAULT = 2, DIRTY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [VA_W-1:0] lk_va = '0;
  logic [PID_W-1:0] lk_pid = '0;
  logic [1:0] lk_kind = '0;
  logic fl_valid = 1'b0;
  logic [VPN_W-1:0] fl_vpn = '0;
  logic [PID_W-1:0] fl_pid = '0;
  logic [PPN_W-1:0] fl_ppn = '0;
  logic [2:0] fl_rights = '0;
  logic fl_dirty = 1'b0;
  logic inv_all = 1'b0;
  logic inv_pid_en = 1'b0;
  logic [PID_W-1:0] inv_pid = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
  logic [PA_W-1:0] rsp_pa;

  always #5 clk = ~clk;

  ptag_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W), .OFS_W(OFS_W)) i_ptag_tlb (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_pid(lk_pid), .lk_kind(lk_kind),
    .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_pid(fl_pid), .fl_ppn(fl_ppn), .fl_rights(fl_rights),
    .fl_dirty(fl_dirty), .inv_all(inv_all), .inv_pid_en(inv_pid_en), .inv_pid(inv_pid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_dirty(rsp_dirty), .rsp_pa(rsp_pa)
  );

  int checks = 0;
  int errors = 0;
  int exp_out_q[$];
  logic [PA_W-1:0] exp_pa_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid, input logic [1:0] kind,
                        input logic [OFS_W-1:0] ofs, input int outcome, input logic [PPN_W-1:0] ppn,
                        input string tag);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_va    = {vpn, ofs};
    lk_pid   = pid;
    lk_kind  = kind;
    exp_out_q.push_back(outcome);
    exp_pa_q.push_back(outcome == MISS ? PA_W'(0) : {ppn, ofs});
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid   = 1'b0;
    fl_valid   = 1'b0;
    inv_all    = 1'b0;
    inv_pid_en = 1'b0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid, input logic [PPN_W-1:0] ppn,
                      input logic [2:0] rights, input logic dirty);
    @(negedge clk);
    lk_valid  = 1'b0;
    fl_valid  = 1'b1;
    fl_vpn    = vpn;
    fl_pid    = pid;
    fl_ppn    = ppn;
    fl_rights = rights;
    fl_dirty  = dirty;
    idle();
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_out_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected response", 1, 0);
      end else begin
        int eo;
        logic [PA_W-1:0] ep;
        string t;
        logic [3:0] act, exp;
        eo = exp_out_q.pop_front();
        ep = exp_pa_q.pop_front();
        t  = tag_q.pop_front();
        act = {rsp_dirty, rsp_fault, rsp_hit, rsp_miss};
        exp = 4'b0001 << eo;
        chk(act == exp, t, "outcome {dirty,fault,hit,miss}", act, exp);
        chk(rsp_pa == ep, t, "rsp_pa", rsp_pa, ep);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault && !rsp_dirty, "R13", "outputs after reset",
        {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty}, 0);
    lookup(19'h5, 4'd1, 2'd0, 13'h0, MISS, 0, "R13");
    idle();

    fill(19'h100, 4'd1, 21'hA, 3'b011, 1'b0);
    lookup(19'h100, 4'd1, 2'd0, 13'h1ABC, HIT,   21'hA, "R4");
    lookup(19'h100, 4'd2, 2'd0, 13'h0123, MISS,  0,     "R3");
    lookup(19'h101, 4'd1, 2'd0, 13'h0, MISS,  0,     "R3");
    lookup(19'h100, 4'd1, 2'd1, 13'h0FFF, DIRTY, 21'hA, "R6");
    lookup(19'h100, 4'd1, 2'd2, 13'h0004, FAULT, 21'hA, "R5");
    lookup(19'h100, 4'd1, 2'd3, 13'h0008, FAULT, 21'hA, "R5");
    idle();

    fill(19'h100, 4'd1, 21'hB, 3'b111, 1'b1);
    lookup(19'h100, 4'd1, 2'd1, 13'h1FFF, HIT, 21'hB, "R10");
    lookup(19'h100, 4'd1, 2'd2, 13'h0010, HIT, 21'hB, "R5");
    idle();

    fill(19'h200, 4'd1, 21'h20, 3'b011, 1'b1);
    fill(19'h300, 4'd1, 21'h30, 3'b001, 1'b0);
    fill(19'h400, 4'd2, 21'h40, 3'b001, 1'b0);
    lookup(19'h100, 4'd1, 2'd0, 13'h0, HIT, 21'hB,  "R10");
    lookup(19'h200, 4'd1, 2'd1, 13'h0, HIT, 21'h20, "R1");
    lookup(19'h300, 4'd1, 2'd0, 13'h0, HIT, 21'h30, "R1");
    lookup(19'h400, 4'd2, 2'd0, 13'h0, HIT, 21'h40, "R1");
    idle();

    fill(19'h500, 4'd1, 21'h50, 3'b001, 1'b0);
    lookup(19'h100, 4'd1, 2'd0, 13'h0, MISS, 0,     "R11");
    lookup(19'h500, 4'd1, 2'd0, 13'h0, HIT,  21'h50, "R11");
    lookup(19'h200, 4'd1, 2'd0, 13'h0, HIT,  21'h20, "R11");
    idle();
    fill(19'h600, 4'd1, 21'h60, 3'b001, 1'b0);
    lookup(19'h200, 4'd1, 2'd0, 13'h0, MISS, 0,     "R11");
    lookup(19'h300, 4'd1, 2'd0, 13'h0, HIT,  21'h30, "R11");
    idle();

    @(negedge clk);
    inv_pid_en = 1'b1;
    inv_pid    = 4'd2;
    idle();
    lookup(19'h400, 4'd2, 2'd0, 13'h0, MISS, 0,      "R9");
    lookup(19'h300, 4'd1, 2'd0, 13'h0, HIT,  21'h30, "R9");
    lookup(19'h500, 4'd1, 2'd0, 13'h0, HIT,  21'h50, "R9");
    lookup(19'h600, 4'd1, 2'd0, 13'h0, HIT,  21'h60, "R9");
    idle();

    fill(19'h700, 4'd3, 21'h70, 3'b001, 1'b0);
    lookup(19'h300, 4'd1, 2'd0, 13'h0, HIT, 21'h30, "R11");
    lookup(19'h700, 4'd3, 2'd0, 13'h0, HIT, 21'h70, "R11");
    idle();
    fill(19'h800, 4'd1, 21'h80, 3'b001, 1'b0);
    lookup(19'h300, 4'd1, 2'd0, 13'h0, MISS, 0,      "R11");
    lookup(19'h500, 4'd1, 2'd0, 13'h0, HIT,  21'h50, "R11");
    lookup(19'h600, 4'd1, 2'd0, 13'h0, HIT,  21'h60, "R11");
    lookup(19'h700, 4'd3, 2'd0, 13'h0, HIT,  21'h70, "R11");
    lookup(19'h800, 4'd1, 2'd0, 13'h0, HIT,  21'h80, "R11");
    idle();

    @(negedge clk);
    inv_all   = 1'b1;
    fl_valid  = 1'b1;
    fl_vpn    = 19'h900;
    fl_pid    = 4'd1;
    fl_ppn    = 21'h90;
    fl_rights = 3'b001;
    fl_dirty  = 1'b0;
    idle();
    lookup(19'h900, 4'd1, 2'd0, 13'h0, HIT,  21'h90, "R12");
    lookup(19'h500, 4'd1, 2'd0, 13'h0, MISS, 0,      "R8");
    lookup(19'h800, 4'd1, 2'd0, 13'h0, MISS, 0,      "R8");
    idle();

    @(negedge clk);
    inv_all = 1'b1;
    idle();
    lookup(19'h900, 4'd1, 2'd0, 13'h0, MISS, 0, "R8");
    idle();
    repeat (3) @(negedge clk);
    chk(exp_out_q.size() == 0, "R2", "responses outstanding", exp_out_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule